// File: doc/BRIEF.md
# Packed Bit-Vector Logic and Inner-Product Unit

This block treats each of its two 128-bit operands as a vector of 128 independent one-bit field elements. It offers three lane-wise operations: sum (XOR), product (AND), and complement of operand A. It also offers two counting operations: the number of set lanes in A, and the binary inner product of A and B. The inner product is the number of lanes where both operands are one. Vector results leave on a 128-bit result bus and counts leave on an 8-bit count bus. Both buses are registered.

Counting is done per 32-bit word. Each word passes through a fixed reduction network that shifts, masks and adds. The network first forms 2-bit partial counts, then 4-bit counts, then byte counts, and then folds the bytes together. The four word counts are added into the final count. For the inner product, the AND of the operands feeds the same counter directly, so no second counter is needed.

Operands enter on a valid/ready stream and results leave on a valid/ready stream. The output stage holds one result. An input is accepted in any cycle where `in_valid` and `in_ready` are both high. `in_ready` is high whenever the output register is empty or is being drained in the same cycle. While the output is offered but not taken, the output stays frozen and no new input is accepted. The opcode travels with the operands on the input stream.

Top module: `bitvec_dot_unit`

## Requirements
- R1: Opcode 3'b000 returns, on `res_vec`, the lane-wise XOR of `op_a` and `op_b`, and returns `res_cnt` = 0.
- R2: Opcode 3'b001 returns, on `res_vec`, the lane-wise AND of `op_a` and `op_b`, and returns `res_cnt` = 0.
- R3: Opcode 3'b010 returns, on `res_vec`, the bitwise complement of `op_a` with `res_cnt` = 0. The value of `op_b` has no effect on this result.
- R4: Opcode 3'b011 returns, on `res_cnt`, the number of one bits in `op_a` (0 to 128), and returns `res_vec` = 0. The value of `op_b` has no effect on this result.
- R5: Opcode 3'b100 returns, on `res_cnt`, the number of bit positions where both `op_a` and `op_b` are one, and returns `res_vec` = 0.
- R6: Opcodes 3'b101, 3'b110 and 3'b111 return zero on both `res_vec` and `res_cnt`.
- R7: The result of an input accepted at a rising clock edge appears, with `out_valid` high, right after that edge. The stage adds exactly one cycle of latency.
- R8: `in_ready` is high exactly when `out_valid` is low or `out_ready` is high.
- R9: While `out_valid` is high and `out_ready` is low, `out_valid`, `res_vec` and `res_cnt` hold their values, and an offered input is not taken.
- R10: While reset is asserted, and directly after it, `out_valid` is low and `res_vec` and `res_cnt` are zero. When `out_ready` is high and no input is offered, `out_valid` falls at the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operand set offered |
| in_ready | output | 1 | Unit can take an operand set this cycle |
| opcode | input | 3 | Operation select (see R1 to R6) |
| op_a | input | 128 | Operand A, one field element per bit |
| op_b | input | 128 | Operand B, one field element per bit |
| out_valid | output | 1 | Result registered and offered |
| out_ready | input | 1 | Consumer takes the offered result |
| res_vec | output | 128 | Lane-wise result |
| res_cnt | output | 8 | Count result |

## Verification
Every result is due one rising edge after the edge that accepted its operands. The bench drives inputs on falling edges. It then samples `out_valid`, `res_vec` and `res_cnt` on the next falling edge, which is the midpoint of the cycle in which the result is first offered. For back-pressure, the bench holds `out_ready` low for several cycles and samples at each falling edge, checking that the old result is unchanged and that `in_ready` stays low. It then releases `out_ready` and expects the waiting operand set to be accepted at that same edge, with its result sampled one falling edge later.

// File: rtl/bitvec_pkg.sv
package bitvec_pkg;
  localparam int unsigned LANES  = 128;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned OP_W   = 3;

  typedef enum logic [OP_W-1:0] {
    OP_XOR  = 3'b000,
    OP_AND  = 3'b001,
    OP_INV  = 3'b010,
    OP_CNTA = 3'b011,
    OP_DOT  = 3'b100
  } bv_op_e;

  function automatic logic is_count_op(input logic [OP_W-1:0] op);
    return (op == OP_CNTA) || (op == OP_DOT);
  endfunction

  function automatic logic is_vector_op(input logic [OP_W-1:0] op);
    return (op == OP_XOR) || (op == OP_AND) || (op == OP_INV);
  endfunction
endpackage

// File: rtl/bitvec_word_count.sv
// One-word population count built from a fixed shift/mask/add network.
module bitvec_word_count #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0]             word_i,
  output logic [$clog2(W+1)-1:0]   count_o
);
  localparam int unsigned CW     = $clog2(W+1);
  localparam int unsigned NFOLD  = $clog2(W) - 3;
  localparam logic [W-1:0] PAIRM = {(W/2){2'b01}};
  localparam logic [W-1:0] NIBM  = {(W/4){4'b0011}};
  localparam logic [W-1:0] BYTEM = {(W/8){8'h0F}};

  logic [W-1:0] pair_cnt;
  logic [W-1:0] nib_cnt;
  logic [W-1:0] fold [NFOLD+1];

  // 2-bit partial counts: each pair minus its upper bit
  assign pair_cnt = word_i - ((word_i >> 1) & PAIRM);
  // 4-bit partial counts
  assign nib_cnt  = (pair_cnt & NIBM) + ((pair_cnt >> 2) & NIBM);
  // byte counts
  assign fold[0]  = (nib_cnt + (nib_cnt >> 4)) & BYTEM;

  // fold bytes together: shift by 8, 16, ...
  for (genvar g = 0; g < NFOLD; g++) begin : g_fold
    assign fold[g+1] = fold[g] + (fold[g] >> (8 << g));
  end

  assign count_o = fold[NFOLD][CW-1:0];
endmodule

// File: rtl/bitvec_lane_ops.sv
// Lane-wise logic and selection of the vector fed to the counter.
module bitvec_lane_ops
  import bitvec_pkg::*;
#(
  parameter int unsigned N = LANES
) (
  input  logic [OP_W-1:0] op_i,
  input  logic [N-1:0]    a_i,
  input  logic [N-1:0]    b_i,
  output logic [N-1:0]    vec_o,
  output logic [N-1:0]    cnt_src_o
);
  logic [N-1:0] lane_and;
  assign lane_and = a_i & b_i;

  always_comb begin
    unique case (op_i)
      OP_XOR:  vec_o = a_i ^ b_i;
      OP_AND:  vec_o = lane_and;
      OP_INV:  vec_o = ~a_i;
      default: vec_o = '0;
    endcase
  end

  // fused inner product: the AND vector feeds the same counter
  always_comb begin
    unique case (op_i)
      OP_CNTA: cnt_src_o = a_i;
      OP_DOT:  cnt_src_o = lane_and;
      default: cnt_src_o = '0;
    endcase
  end
endmodule

// File: rtl/bitvec_count_tree.sv
// Splits the vector into words, counts each, sums the word counts.
module bitvec_count_tree
  import bitvec_pkg::*;
#(
  parameter int unsigned N  = LANES,
  parameter int unsigned WW = WORD_W
) (
  input  logic [N-1:0]             vec_i,
  output logic [$clog2(N+1)-1:0]   total_o
);
  localparam int unsigned NW  = N / WW;
  localparam int unsigned WCW = $clog2(WW+1);
  localparam int unsigned TCW = $clog2(N+1);

  logic [WCW-1:0] word_cnt [NW];

  for (genvar w = 0; w < NW; w++) begin : g_word
    bitvec_word_count #(.W(WW)) u_wc (
      .word_i  (vec_i[w*WW +: WW]),
      .count_o (word_cnt[w])
    );
  end

  always_comb begin
    total_o = '0;
    for (int i = 0; i < NW; i++) total_o = total_o + TCW'(word_cnt[i]);
  end
endmodule

// File: rtl/bitvec_dot_unit.sv
module bitvec_dot_unit
  import bitvec_pkg::*;
(
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      in_valid,
  output logic                      in_ready,
  input  logic [OP_W-1:0]           opcode,
  input  logic [LANES-1:0]          op_a,
  input  logic [LANES-1:0]          op_b,
  output logic                      out_valid,
  input  logic                      out_ready,
  output logic [LANES-1:0]          res_vec,
  output logic [$clog2(LANES+1)-1:0] res_cnt
);
  localparam int unsigned CNT_W = $clog2(LANES+1);

  logic [LANES-1:0] vec_next;
  logic [LANES-1:0] cnt_src;
  logic [CNT_W-1:0] cnt_next;
  logic             accept;

  bitvec_lane_ops #(.N(LANES)) u_ops (
    .op_i      (opcode),
    .a_i       (op_a),
    .b_i       (op_b),
    .vec_o     (vec_next),
    .cnt_src_o (cnt_src)
  );

  bitvec_count_tree #(.N(LANES), .WW(WORD_W)) u_cnt (
    .vec_i   (cnt_src),
    .total_o (cnt_next)
  );

  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      res_vec   <= '0;
      res_cnt   <= '0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) begin
        res_vec <= vec_next;
        res_cnt <= cnt_next;
      end
    end
  end

  // R7: accepted input yields an offered result next cycle
  a_r7_result_next: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> out_valid);
  // R9: stalled output is frozen
  a_r9_hold_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(res_vec) && $stable(res_cnt)));
  // R10: drained with nothing offered empties the stage
  a_r10_drain_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_valid && out_ready) |=> !out_valid);
  // R4: count never exceeds lane count
  a_r4_cnt_range: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (res_cnt <= CNT_W'(LANES)));
  // R6: counts and vectors never both nonzero
  a_r6_one_bus_used: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (res_vec == '0 || res_cnt == '0));
  // R6: unused opcodes give zeros
  a_r6_unused_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !is_count_op(opcode) && !is_vector_op(opcode))
      |=> (res_vec == '0 && res_cnt == '0));
endmodule

// File: tb/tb_bitvec_dot_unit.sv
module tb_bitvec_dot_unit;
  localparam int CLK_PERIOD = 10;
  localparam int N = 128;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [2:0] opcode = '0;
  logic [N-1:0] op_a = '0, op_b = '0;
  logic out_valid;
  logic out_ready = 1'b1;
  logic [N-1:0] res_vec;
  logic [7:0] res_cnt;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bitvec_dot_unit dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .opcode(opcode), .op_a(op_a), .op_b(op_b), .out_valid(out_valid),
    .out_ready(out_ready), .res_vec(res_vec), .res_cnt(res_cnt)
  );

  function automatic int ones(input logic [N-1:0] v);
    int c = 0;
    for (int i = 0; i < N; i++) if (v[i]) c++;
    return c;
  endfunction

  function automatic logic [N-1:0] ref_vec(input logic [2:0] op, input logic [N-1:0] a, b);
    case (op)
      3'b000: return a ^ b;
      3'b001: return a & b;
      3'b010: return ~a;
      default: return '0;
    endcase
  endfunction

  function automatic logic [7:0] ref_cnt(input logic [2:0] op, input logic [N-1:0] a, b);
    case (op)
      3'b011: return 8'(ones(a));
      3'b100: return 8'(ones(a & b));
      default: return '0;
    endcase
  endfunction

  task automatic check(input string req, input logic [N-1:0] act, exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic string tag_of(input logic [2:0] op);
    case (op)
      3'b000: return "R1";
      3'b001: return "R2";
      3'b010: return "R3";
      3'b011: return "R4";
      3'b100: return "R5";
      default: return "R6";
    endcase
  endfunction

  // drive one operand set with out_ready high; result sampled next negedge (R7)
  task automatic run_op(input logic [2:0] op, input logic [N-1:0] a, b);
    opcode = op; op_a = a; op_b = b; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check("R7", N'(out_valid), N'(1));
    check(tag_of(op), res_vec, ref_vec(op, a, b));
    check(tag_of(op), N'(res_cnt), N'(ref_cnt(op, a, b)));
  endtask

  function automatic logic [N-1:0] rnd128();
    return {$urandom(), $urandom(), $urandom(), $urandom()};
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [N-1:0] hold_v;
    logic [7:0] hold_c;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    // R10: reset state
    check("R10", N'(out_valid), N'(0));
    check("R10", res_vec, '0);
    check("R10", N'(res_cnt), N'(0));
    rst_n = 1'b1;
    @(negedge clk);
    check("R10", N'(out_valid), N'(0));

    // directed corners
    run_op(3'b011, '0, '1);
    run_op(3'b011, '1, '0);
    run_op(3'b100, '1, '1);
    run_op(3'b100, '1, '0);
    for (int k = 0; k < N; k += 31) begin
      run_op(3'b011, N'(1) << k, '1);
      run_op(3'b100, N'(1) << k, N'(1) << k);
      run_op(3'b100, N'(1) << k, ~(N'(1) << k));
    end
    // R3: op_b has no effect on complement
    run_op(3'b010, {4{32'hA5A5_0F0F}}, '0);
    run_op(3'b010, {4{32'hA5A5_0F0F}}, '1);
    // R4: op_b has no effect on count of A
    run_op(3'b011, {4{32'h8000_0001}}, {4{32'h1234_5678}});
    run_op(3'b000, {4{32'hFFFF_0000}}, {4{32'h0F0F_0F0F}});
    run_op(3'b001, {4{32'hFFFF_0000}}, {4{32'h0F0F_0F0F}});
    // R6: unused codes
    run_op(3'b101, '1, '1);
    run_op(3'b110, '1, '1);
    run_op(3'b111, '1, '1);

    // R10: idle drain
    @(negedge clk);
    check("R10", N'(out_valid), N'(0));

    // R8/R9: back-pressure
    out_ready = 1'b0;
    opcode = 3'b100; op_a = {4{32'hFF00_FF00}}; op_b = '1; in_valid = 1'b1;
    @(negedge clk);
    check("R7", N'(out_valid), N'(1));
    check("R8", N'(in_ready), N'(0));
    hold_v = res_vec; hold_c = res_cnt;
    check("R5", N'(res_cnt), N'(64));
    opcode = 3'b000; op_a = '1; op_b = '0;
    for (int s = 0; s < 4; s++) begin
      @(negedge clk);
      check("R9", N'(out_valid), N'(1));
      check("R9", N'(res_cnt), N'(hold_c));
      check("R9", res_vec, hold_v);
      check("R8", N'(in_ready), N'(0));
    end
    out_ready = 1'b1;
    #1;
    check("R8", N'(in_ready), N'(1));
    @(negedge clk);
    in_valid = 1'b0;
    check("R9", N'(out_valid), N'(1));
    check("R1", res_vec, '1);
    check("R1", N'(res_cnt), N'(0));

    // random mix
    for (int t = 0; t < 300; t++) begin
      run_op(3'($urandom_range(0, 7)), rnd128(), rnd128());
    end
    // sparse random for count coverage
    for (int t = 0; t < 100; t++) begin
      logic [N-1:0] a = rnd128() & rnd128() & rnd128();
      run_op(3'($urandom_range(3, 4)), a, rnd128() | rnd128());
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule